// File: doc/BRIEF.md
# Multi-Mode Storage Register Bank

This block is the storage stage of a bank of logic cells: `WIDTH` one-bit registers that share one set of control inputs. A static two-bit mode input sets how every bit treats its two data inputs. The choices are plain data capture, toggle-on-one, set/reset/toggle with two inputs, and set/reset with two inputs. Static select inputs choose which of two clocks drives the bank and which of two clock enables gates it. The bank can also reload from a shift path. Bit 0 takes a serial input, bit i takes bit i-1, and the top bit leaves the bank as a serial output that feeds the next bank.

Asynchronous controls act at once. An active-low device reset and two cluster clears force zero. A shared preset/load pin either forces all ones or makes the outputs follow an asynchronous data word, as static configuration chooses. Clears win over preset/load. Synchronous clear and synchronous load act only at an enabled clock edge. The clear beats the load, and the load beats the mode function. A feedback output always shows the stored register value. The main output also shows the asynchronous override while it is active.

Top module: `multimode_reg`

## Requirements
- R1: While `dev_rst_n` is 0, or `aclr_a` or `aclr_b` is 1, `q` and `chain_out` are 0 without waiting for a clock edge. This holds whatever `apl` does. At the next edge of the selected clock, `fb_out` is also 0.
- R2: While `apl` is 1 and no clear of R1 is active, `q` is all ones when `cfg_apl_load` is 0 and equals `adata` when `cfg_apl_load` is 1. `q` tracks changes of `adata` without a clock edge. The register captures the same value at each edge of the selected clock. After `apl` falls, the register keeps the last captured value.
- R3: When `cfg_mode` is 0 (data mode), each enabled edge loads `d_in`.
- R4: When `cfg_mode` is 1 (toggle mode), each enabled edge inverts every bit whose `d_in` bit is 1. Bits whose `d_in` bit is 0 keep their value.
- R5: When `cfg_mode` is 2, `d_in` is J and `k_in` is K per bit, and each enabled edge applies the following: J=0,K=0 holds; J=0,K=1 clears; J=1,K=0 sets; J=1,K=1 toggles.
- R6: When `cfg_mode` is 3, `d_in` is S and `k_in` is R per bit, and each enabled edge applies the following: S=0,R=0 holds; S=1,R=0 sets; S=0,R=1 clears; S=1,R=1 holds.
- R7: At an enabled edge, `sync_clr`=1 loads zero in any mode, even with `sync_ld`=1. Otherwise, `sync_ld`=1 loads the load source in place of the mode function. That source is `d_in` when `cfg_ld_chain` is 0.
- R8: With `sync_ld`=1 and `cfg_ld_chain`=1, an enabled edge shifts the stored word up by one bit and places `chain_in` in bit 0. `chain_out` always shows bit WIDTH-1 of the stored word.
- R9: The active enable is `ena_a` when `cfg_ena_sel` is 0 and `ena_b` when it is 1. While the active enable is 0, clock edges leave the stored word unchanged, whatever the values of `sync_clr`, `sync_ld` and the data inputs.
- R10: The register is clocked by `clk_a` when `cfg_clk_sel` is 0 and by `clk_b` when it is 1. Edges of the clock that is not selected have no effect.
- R11: `fb_out` is the stored word. It equals `q` whenever neither `apl` nor any R1 clear is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Cluster clock A |
| clk_b | input | 1 | Cluster clock B |
| cfg_clk_sel | input | 1 | Static clock select, 1 picks clk_b |
| ena_a | input | 1 | Cluster clock enable A |
| ena_b | input | 1 | Cluster clock enable B |
| cfg_ena_sel | input | 1 | Static enable select, 1 picks ena_b |
| cfg_mode | input | 2 | 0 data, 1 toggle, 2 set/reset/toggle, 3 set/reset |
| cfg_ld_chain | input | 1 | Synchronous load source, 1 picks the shift path |
| cfg_apl_load | input | 1 | 1: apl loads adata; 0: apl presets to ones |
| dev_rst_n | input | 1 | Device-wide asynchronous reset, active low |
| aclr_a | input | 1 | Cluster asynchronous clear A |
| aclr_b | input | 1 | Cluster asynchronous clear B |
| apl | input | 1 | Asynchronous preset/load control |
| adata | input | WIDTH | Asynchronous load data |
| sync_clr | input | 1 | Cluster synchronous clear |
| sync_ld | input | 1 | Cluster synchronous load |
| d_in | input | WIDTH | Data / T / J / S input |
| k_in | input | WIDTH | K / R input |
| chain_in | input | 1 | Shift input from the previous bank |
| q | output | WIDTH | Register output including async override |
| fb_out | output | WIDTH | Stored register value (feedback) |
| chain_out | output | 1 | Shift output to the next bank |

## Verification
A corrupted stored bit shows up on `fb_out` and `q` at the sample that follows the very next selected edge. It shows up on `chain_out` as well when the bit is the top one. The mode and priority checks compare the word after each edge with a reference step taken from the requirement tables. A wrong priority among the asynchronous sources appears on `q` within a nanosecond, with no clock involved. A wrong capture of the asynchronous value appears on `fb_out` one edge later.

// File: rtl/multimode_reg_pkg.sv
package multimode_reg_pkg;

    typedef enum logic [1:0] {
        MODE_DATA   = 2'd0,
        MODE_TOGGLE = 2'd1,
        MODE_JK     = 2'd2,
        MODE_SR     = 2'd3
    } reg_mode_e;

endpackage

// File: rtl/multimode_reg_fn.sv
// Per-bit next-state function of the selected storage mode.
module multimode_reg_fn
    import multimode_reg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [1:0]       cfg_mode,
    input  logic [WIDTH-1:0] cur_q,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic [WIDTH-1:0] fn_d
);

    reg_mode_e mode_sel;

    assign mode_sel = reg_mode_e'(cfg_mode);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            unique case (mode_sel)
                MODE_DATA:   fn_d[b] = in_a[b];
                MODE_TOGGLE: fn_d[b] = cur_q[b] ^ in_a[b];
                MODE_JK: begin
                    unique case ({in_a[b], in_b[b]})
                        2'b00:   fn_d[b] = cur_q[b];
                        2'b01:   fn_d[b] = 1'b0;
                        2'b10:   fn_d[b] = 1'b1;
                        default: fn_d[b] = ~cur_q[b];
                    endcase
                end
                default: begin
                    unique case ({in_a[b], in_b[b]})
                        2'b10:   fn_d[b] = 1'b1;
                        2'b01:   fn_d[b] = 1'b0;
                        default: fn_d[b] = cur_q[b];
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/multimode_reg_sync.sv
// Clock-enable selection and synchronous clear/load layering.
module multimode_reg_sync #(
    parameter int WIDTH = 4
) (
    input  logic             ena_a,
    input  logic             ena_b,
    input  logic             cfg_ena_sel,
    input  logic             sync_clr,
    input  logic             sync_ld,
    input  logic             cfg_ld_chain,
    input  logic [WIDTH-1:0] ld_data,
    input  logic [WIDTH-1:0] cur_q,
    input  logic             chain_in,
    input  logic [WIDTH-1:0] fn_d,
    output logic             upd_en,
    output logic [WIDTH-1:0] upd_d
);

    logic [WIDTH-1:0] shift_d;
    logic [WIDTH-1:0] ld_src;

    if (WIDTH == 1) begin : g_shift_one
        assign shift_d = chain_in;
    end else begin : g_shift_many
        assign shift_d = {cur_q[WIDTH-2:0], chain_in};
    end

    always_comb begin
        upd_en = cfg_ena_sel ? ena_b : ena_a;
        ld_src = cfg_ld_chain ? shift_d : ld_data;
        if (sync_clr) begin
            upd_d = '0;
        end else if (sync_ld) begin
            upd_d = ld_src;
        end else begin
            upd_d = fn_d;
        end
    end

endmodule

// File: rtl/multimode_reg_async.sv
// Resolution of the asynchronous sources: clears first, then preset/load.
module multimode_reg_async #(
    parameter int WIDTH = 4
) (
    input  logic             dev_rst_n,
    input  logic             aclr_a,
    input  logic             aclr_b,
    input  logic             apl,
    input  logic             cfg_apl_load,
    input  logic [WIDTH-1:0] adata,
    output logic             arst,
    output logic             aset,
    output logic [WIDTH-1:0] aval
);

    always_comb begin
        arst = ~dev_rst_n | aclr_a | aclr_b;
        aset = apl & ~arst;
        aval = cfg_apl_load ? adata : {WIDTH{1'b1}};
    end

endmodule

// File: rtl/multimode_reg.sv
module multimode_reg
    import multimode_reg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             cfg_clk_sel,
    input  logic             ena_a,
    input  logic             ena_b,
    input  logic             cfg_ena_sel,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_ld_chain,
    input  logic             cfg_apl_load,
    input  logic             dev_rst_n,
    input  logic             aclr_a,
    input  logic             aclr_b,
    input  logic             apl,
    input  logic [WIDTH-1:0] adata,
    input  logic             sync_clr,
    input  logic             sync_ld,
    input  logic [WIDTH-1:0] d_in,
    input  logic [WIDTH-1:0] k_in,
    input  logic             chain_in,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] fb_out,
    output logic             chain_out
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } store_t;

    store_t           st_d;
    store_t           st_q;
    logic             clk_sel;
    logic             arst;
    logic             aset;
    logic [WIDTH-1:0] aval;
    logic [WIDTH-1:0] fn_d;
    logic             upd_en;
    logic [WIDTH-1:0] upd_d;

    // Static clock choice; switching it during operation is not supported.
    assign clk_sel = cfg_clk_sel ? clk_b : clk_a;

    multimode_reg_fn #(.WIDTH(WIDTH)) i_fn (
        .cfg_mode (cfg_mode),
        .cur_q    (st_q.word),
        .in_a     (d_in),
        .in_b     (k_in),
        .fn_d     (fn_d)
    );

    multimode_reg_sync #(.WIDTH(WIDTH)) i_sync (
        .ena_a        (ena_a),
        .ena_b        (ena_b),
        .cfg_ena_sel  (cfg_ena_sel),
        .sync_clr     (sync_clr),
        .sync_ld      (sync_ld),
        .cfg_ld_chain (cfg_ld_chain),
        .ld_data      (d_in),
        .cur_q        (st_q.word),
        .chain_in     (chain_in),
        .fn_d         (fn_d),
        .upd_en       (upd_en),
        .upd_d        (upd_d)
    );

    multimode_reg_async #(.WIDTH(WIDTH)) i_async (
        .dev_rst_n    (dev_rst_n),
        .aclr_a       (aclr_a),
        .aclr_b       (aclr_b),
        .apl          (apl),
        .cfg_apl_load (cfg_apl_load),
        .adata        (adata),
        .arst         (arst),
        .aset         (aset),
        .aval         (aval)
    );

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.word = upd_d;
        end
    end

    always_ff @(posedge clk_sel or posedge arst or posedge aset) begin
        if (arst) begin
            st_q.word <= '0;
        end else if (aset) begin
            st_q.word <= aval;
        end else begin
            st_q <= st_d;
        end
    end

    // The output shows the async value at once; the register catches up at the next edge.
    always_comb begin
        if (arst) begin
            q = '0;
        end else if (aset) begin
            q = aval;
        end else begin
            q = st_q.word;
        end
        fb_out    = st_q.word;
        chain_out = arst ? 1'b0 : st_q.word[TOP];
    end

    assert_async_clear_R1: assert property (@(posedge clk_sel) disable iff (!dev_rst_n)
        (aclr_a || aclr_b) |-> (q == '0 && !chain_out));

    assert_async_load_R2: assert property (@(posedge clk_sel) disable iff (!dev_rst_n)
        (apl && cfg_apl_load && !aclr_a && !aclr_b) |-> (q == adata));

    assert_sync_clear_R7: assert property (@(posedge clk_sel) disable iff (!dev_rst_n)
        (upd_en && sync_clr && !arst && !aset) |=> (fb_out == '0 || arst || aset));

    assert_disabled_hold_R9: assert property (@(posedge clk_sel) disable iff (!dev_rst_n)
        (!upd_en && !arst && !aset) |=> ($stable(fb_out) || arst || aset));

    assert_jk_toggle_R5: assert property (@(posedge clk_sel) disable iff (!dev_rst_n)
        (upd_en && !sync_clr && !sync_ld && !arst && !aset && cfg_mode == 2'd2
         && d_in == '1 && k_in == '1)
        |=> (fb_out == ~$past(fb_out) || arst || aset));

endmodule

// File: tb/test_multimode_reg.sv
module test_multimode_reg;

    localparam int W = 4;

    logic         clk_a = 1'b0;
    logic         clkb_run = 1'b0;
    logic         clk_b;
    logic         cfg_clk_sel = 1'b0;
    logic         ena_a = 1'b1;
    logic         ena_b = 1'b0;
    logic         cfg_ena_sel = 1'b0;
    logic [1:0]   cfg_mode = 2'd0;
    logic         cfg_ld_chain = 1'b0;
    logic         cfg_apl_load = 1'b0;
    logic         dev_rst_n = 1'b0;
    logic         aclr_a = 1'b0;
    logic         aclr_b = 1'b0;
    logic         apl = 1'b0;
    logic [W-1:0] adata = '0;
    logic         sync_clr = 1'b0;
    logic         sync_ld = 1'b0;
    logic [W-1:0] d_in = '0;
    logic [W-1:0] k_in = '0;
    logic         chain_in = 1'b0;
    logic [W-1:0] q;
    logic [W-1:0] fb_out;
    logic         chain_out;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk_a = ~clk_a;
    assign clk_b = clk_a & clkb_run;

    multimode_reg #(.WIDTH(W)) i_multimode_reg (
        .clk_a(clk_a), .clk_b(clk_b), .cfg_clk_sel(cfg_clk_sel),
        .ena_a(ena_a), .ena_b(ena_b), .cfg_ena_sel(cfg_ena_sel),
        .cfg_mode(cfg_mode), .cfg_ld_chain(cfg_ld_chain), .cfg_apl_load(cfg_apl_load),
        .dev_rst_n(dev_rst_n), .aclr_a(aclr_a), .aclr_b(aclr_b), .apl(apl),
        .adata(adata), .sync_clr(sync_clr), .sync_ld(sync_ld), .d_in(d_in),
        .k_in(k_in), .chain_in(chain_in), .q(q), .fb_out(fb_out), .chain_out(chain_out)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Reference next value for one enabled edge in the given mode.
    function automatic logic [W-1:0] ref_step(input logic [1:0] m, input logic [W-1:0] cur,
                                              input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            case (m)
                2'd0: r[i] = a[i];
                2'd1: r[i] = a[i] ? ~cur[i] : cur[i];
                2'd2: r[i] = (a[i] && b[i]) ? ~cur[i] : (a[i] ? 1'b1 : (b[i] ? 1'b0 : cur[i]));
                default: r[i] = (a[i] && !b[i]) ? 1'b1 : ((!a[i] && b[i]) ? 1'b0 : cur[i]);
            endcase
        end
        return r;
    endfunction

    task automatic step();
        @(posedge clk_a);
        @(negedge clk_a);
    endtask

    task automatic load_word(input logic [W-1:0] v);
        cfg_ld_chain = 1'b0;
        sync_ld = 1'b1;
        d_in = v;
        step();
        sync_ld = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1 reset q", q, '0);
        check("R1 reset chain_out", W'(chain_out), '0);
        step();
        check("R1 reset fb_out", fb_out, '0);
        dev_rst_n = 1'b1;
        step();
    endtask

    task automatic t_data_mode();
        cfg_mode = 2'd0;
        d_in = 4'hA;
        step();
        check("R3 data load A", q, 4'hA);
        check("R11 fb equals q", fb_out, 4'hA);
        d_in = 4'h5;
        step();
        check("R3 data load 5", q, 4'h5);
    endtask

    task automatic t_toggle_mode();
        load_word(4'h3);
        cfg_mode = 2'd1;
        d_in = 4'h6;
        step();
        check("R4 toggle 3^6", q, 4'h5);
        d_in = 4'h0;
        step();
        check("R4 toggle zero holds", q, 4'h5);
    endtask

    task automatic t_jk_mode();
        logic [W-1:0] e;
        load_word(4'h5);
        cfg_mode = 2'd2;
        d_in = 4'b0011;
        k_in = 4'b0110;
        e = ref_step(2'd2, 4'h5, d_in, k_in);
        step();
        check("R5 jk mixed", q, e);
        d_in = 4'hF;
        k_in = 4'hF;
        step();
        check("R5 jk both one toggles", q, ~e);
        k_in = 4'h0;
    endtask

    task automatic t_sr_mode();
        logic [W-1:0] e;
        load_word(4'h9);
        cfg_mode = 2'd3;
        d_in = 4'b0110;
        k_in = 4'b0011;
        e = ref_step(2'd3, 4'h9, d_in, k_in);
        step();
        check("R6 sr mixed", q, e);
        d_in = 4'hF;
        k_in = 4'hF;
        step();
        check("R6 sr both one holds", q, e);
        k_in = 4'h0;
    endtask

    task automatic t_sync_priority();
        load_word(4'h5);
        cfg_mode = 2'd1;
        sync_clr = 1'b1;
        sync_ld = 1'b1;
        d_in = 4'hF;
        step();
        check("R7 clear beats load", q, 4'h0);
        sync_clr = 1'b0;
        d_in = 4'hA;
        step();
        check("R7 load beats toggle", q, 4'hA);
        sync_ld = 1'b0;
    endtask

    task automatic t_chain();
        load_word(4'h0);
        cfg_ld_chain = 1'b1;
        sync_ld = 1'b1;
        chain_in = 1'b1;
        step();
        check("R8 shift in one", q, 4'b0001);
        step();
        chain_in = 1'b0;
        step();
        check("R8 shift pattern", q, 4'b0110);
        step();
        check("R8 chain_out top bit", W'(chain_out), 4'h1);
        sync_ld = 1'b0;
        cfg_ld_chain = 1'b0;
    endtask

    task automatic t_enable();
        load_word(4'h6);
        cfg_mode = 2'd0;
        ena_a = 1'b0;
        sync_clr = 1'b1;
        d_in = 4'h9;
        step();
        check("R9 disabled ignores clear", fb_out, 4'h6);
        sync_clr = 1'b0;
        cfg_ena_sel = 1'b1;
        ena_a = 1'b1;
        ena_b = 1'b0;
        step();
        check("R9 enable b selected low holds", q, 4'h6);
        ena_b = 1'b1;
        step();
        check("R9 enable b updates", q, 4'h9);
        cfg_ena_sel = 1'b0;
    endtask

    task automatic t_clock_select();
        cfg_mode = 2'd0;
        cfg_clk_sel = 1'b1;
        d_in = 4'hC;
        step();
        step();
        check("R10 unselected clock ignored", q, 4'h9);
        clkb_run = 1'b1;
        step();
        check("R10 clock b captures", q, 4'hC);
        clkb_run = 1'b0;
        cfg_clk_sel = 1'b0;
    endtask

    task automatic t_async_directed();
        ena_a = 1'b0;
        load_hold_note();
        cfg_apl_load = 1'b0;
        apl = 1'b1;
        aclr_b = 1'b1;
        #1;
        check("R1 clear beats preset", q, 4'h0);
        aclr_b = 1'b0;
        #1;
        check("R2 preset ones", q, 4'hF);
        apl = 1'b0;
        cfg_apl_load = 1'b1;
        adata = 4'h3;
        step();
        apl = 1'b1;
        #1;
        check("R2 load follows adata", q, 4'h3);
        adata = 4'hD;
        #1;
        check("R2 load tracks change", q, 4'hD);
        step();
        apl = 1'b0;
        step();
        check("R2 holds after release", fb_out, 4'hD);
        check("R11 q matches fb", q, 4'hD);
        ena_a = 1'b1;
    endtask

    task automatic load_hold_note();
        #1;
    endtask

    task automatic t_async_random();
        logic [W-1:0] m;
        ena_a = 1'b0;
        m = fb_out;
        for (int it = 0; it < 40; it++) begin
            dev_rst_n = ($urandom_range(0, 7) != 0);
            aclr_a = ($urandom_range(0, 5) == 0);
            aclr_b = ($urandom_range(0, 5) == 0);
            apl = $urandom_range(0, 1);
            cfg_apl_load = $urandom_range(0, 1);
            adata = W'($urandom);
            if (!dev_rst_n || aclr_a || aclr_b) m = '0;
            else if (apl) m = cfg_apl_load ? adata : '1;
            #1;
            check("R1 R2 random async q", q, m);
            step();
            check("R1 R2 random async fb", fb_out, m);
        end
        dev_rst_n = 1'b1;
        aclr_a = 1'b0;
        aclr_b = 1'b0;
        apl = 1'b0;
        step();
        ena_a = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk_a);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        @(negedge clk_a);
        t_reset();
        t_data_mode();
        t_toggle_mode();
        t_jk_mode();
        t_sr_mode();
        t_sync_priority();
        t_chain();
        t_enable();
        t_clock_select();
        t_async_directed();
        t_async_random();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule